// File: doc/BRIEF.md
# Floating-Point Status and Exception Control

This block holds the control and status word that sits next to a floating-point arithmetic unit. Software loads the word through a write port. The block turns the word's rounding and denormal fields into two plain control lines for the arithmetic unit. At the end of every floating-point operation it takes in the five exception indications that the operation reports.

Each qualifying operation clears the flag field and refills it with that operation's exceptions. The new flags are then merged into a cause field that accumulates across operations. The merged cause is masked with the enable field. When the operation reported at least one exception and the masked result is non-zero, the block raises a single-cycle trap request carrying a fixed exception code.

A compare operation updates the word only when its result is unordered. Ordered compares leave the word untouched.

Top module: `fp_status_ctl`

## Requirements
- R1: A load writes `ld_data & 0x003FFFFF` into the word, so bits 21:0 take the loaded value and bits 31:22 always read as zero. The result is visible on `csr_value` in the cycle after `ld_en`.
- R2: The rounding field is bits 1:0. Encoding 2'b01 (round toward zero) drives `rnd_trunc` high. Encodings 2'b00, 2'b10 and 2'b11 drive it low, which selects round-to-nearest-even.
- R3: Bit 18 of the word drives `flush_zero` directly.
- R4: After reset the word reads zero, and `rnd_trunc`, `flush_zero`, `trap_req` and `trap_code` are all zero.
- R5: A qualifying operation (`op_done` high, `ld_en` low, and not an ordered compare) replaces the flag field, bits 6:2, with `op_exc` in the cycle after the strobe. The `op_exc` bit order is: bit 4 invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow, bit 0 inexact. Exception bit i lands in word bit 2+i.
- R6: The same update ORs the new flags into the cause field, bits 16:12, with exception bit i going to word bit 12+i. The enable field (bits 11:7), the rounding field, bit 18 and the spare bits 17 and 21:19 keep their values.
- R7: If a qualifying operation has a non-zero `op_exc`, and the updated cause ANDed with the enable field (enable bit 7+i pairs with exception bit i) is non-zero, then `trap_req` is high for exactly the cycle after the strobe. In that cycle `trap_code` is 0x120. Otherwise `trap_code` is zero.
- R8: A qualifying operation with `op_exc` equal to zero raises no trap, even when the accumulated cause and the enables still overlap. Its flag field becomes zero.
- R9: A strobe with `op_cmp` high and `op_unordered` low leaves the whole word unchanged and raises no trap. With `op_unordered` high, the compare updates exactly as in R5 to R7.
- R10: When `ld_en` and `op_done` are high in the same cycle, the load wins. The operation's exceptions are dropped and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Software load strobe |
| ld_data | input | 32 | Value to load (masked) |
| csr_value | output | 32 | Current control/status word |
| op_done | input | 1 | Floating-point operation completed |
| op_cmp | input | 1 | Completed operation is a compare |
| op_unordered | input | 1 | Compare result was unordered |
| op_exc | input | 5 | Exceptions reported by the operation |
| rnd_trunc | output | 1 | Arithmetic unit rounds toward zero |
| flush_zero | output | 1 | Arithmetic unit flushes denormals to zero |
| trap_req | output | 1 | Exception trap request (one cycle) |
| trap_code | output | 12 | Exception code, 0x120 while trapping |

## Verification
The bench first preloads flags that the next operation must wipe. A design that kept flags sticky would show stale bits in the flag field. It then runs a zero-exception operation while the accumulated cause still overlaps the enables. A design that traps on the cause field alone would raise a spurious trap there.

Ordered and unordered compares are driven with the same exception vector. This catches a design that updates on every compare, and also one that ignores compares entirely. A load that coincides with an operation checks that the exception vector does not leak into the loaded word. All four rounding encodings are swept, which catches a decode that truncates on more than one encoding.

// File: rtl/fp_status_pkg.sv
package fp_status_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned EXC_W    = 5;
    localparam int unsigned RM_W     = 2;
    localparam int unsigned CODE_W   = 12;

    localparam logic [WORD_W-1:0] WR_MASK   = 32'h003F_FFFF;
    localparam logic [RM_W-1:0]   RM_TOZERO = 2'b01;
    localparam logic [CODE_W-1:0] FPU_TRAP_CODE = 12'h120;

    // Exception bit positions inside the 5-bit vector
    localparam int unsigned EX_INEXACT  = 0;
    localparam int unsigned EX_UNDER    = 1;
    localparam int unsigned EX_OVER     = 2;
    localparam int unsigned EX_DIVZERO  = 3;
    localparam int unsigned EX_INVALID  = 4;

    typedef logic [EXC_W-1:0] exc_vec_t;

    // Word layout, MSB first: reserved 31:22, spare 21:19, denormal 18,
    // spare 17, cause 16:12, enable 11:7, flags 6:2, rounding 1:0
    typedef struct packed {
        logic [9:0] rsvd;
        logic [2:0] spare_hi;
        logic       dnorm;
        logic       spare_lo;
        exc_vec_t   cause;
        exc_vec_t   enable;
        exc_vec_t   flags;
        logic [RM_W-1:0] rmode;
    } status_word_t;

    typedef struct packed {
        logic      valid;
        logic      cmp;
        logic      unordered;
        exc_vec_t  exc;
    } op_report_t;

    function automatic status_word_t apply_load(input logic [WORD_W-1:0] d);
        return status_word_t'(d & WR_MASK);
    endfunction

    function automatic logic op_qualifies(input op_report_t r, input logic ld);
        return r.valid && !ld && !(r.cmp && !r.unordered);
    endfunction

endpackage

// File: rtl/fp_round_ctl.sv
module fp_round_ctl
    import fp_status_pkg::*;
(
    input  logic [RM_W-1:0] rmode,
    input  logic            dnorm,
    output logic            rnd_trunc,
    output logic            flush_zero
);
    always_comb begin
        rnd_trunc  = (rmode == RM_TOZERO);
        flush_zero = dnorm;
    end
endmodule

// File: rtl/fp_flag_merge.sv
module fp_flag_merge
    import fp_status_pkg::*;
#(
    parameter int unsigned N_EXC = EXC_W
) (
    input  status_word_t cur,
    input  exc_vec_t     exc,
    output status_word_t nxt,
    output logic         trap_hit
);
    logic [N_EXC-1:0] cause_new;
    logic [N_EXC-1:0] armed;

    generate
        for (genvar i = 0; i < N_EXC; i++) begin : g_bit
            assign cause_new[i] = cur.cause[i] | exc[i];
            assign armed[i]     = cause_new[i] & cur.enable[i];
        end
    endgenerate

    always_comb begin
        nxt       = cur;
        nxt.flags = exc;
        nxt.cause = cause_new;
        trap_hit  = (|exc) && (|armed);
    end
endmodule

// File: rtl/fp_trap_out.sv
module fp_trap_out
    import fp_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    output logic              trap_req,
    output logic [CODE_W-1:0] trap_code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            trap_req  <= 1'b0;
            trap_code <= '0;
        end else begin
            trap_req  <= fire;
            trap_code <= fire ? FPU_TRAP_CODE : '0;
        end
    end
endmodule

// File: rtl/fp_status_ctl.sv
module fp_status_ctl
    import fp_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [31:0]       ld_data,
    output logic [31:0]       csr_value,
    input  logic              op_done,
    input  logic              op_cmp,
    input  logic              op_unordered,
    input  logic [4:0]        op_exc,
    output logic              rnd_trunc,
    output logic              flush_zero,
    output logic              trap_req,
    output logic [11:0]       trap_code
);
    status_word_t word_q;
    status_word_t word_upd;
    op_report_t   rpt;
    logic         take_op;
    logic         hit;

    always_comb begin
        rpt.valid     = op_done;
        rpt.cmp       = op_cmp;
        rpt.unordered = op_unordered;
        rpt.exc       = op_exc;
        take_op       = op_qualifies(rpt, ld_en);
    end

    fp_flag_merge #(.N_EXC(EXC_W)) u_merge (
        .cur      (word_q),
        .exc      (rpt.exc),
        .nxt      (word_upd),
        .trap_hit (hit)
    );

    always_ff @(posedge clk) begin
        if (rst)          word_q <= '0;
        else if (ld_en)   word_q <= apply_load(ld_data);
        else if (take_op) word_q <= word_upd;
    end

    fp_round_ctl u_round (
        .rmode      (word_q.rmode),
        .dnorm      (word_q.dnorm),
        .rnd_trunc  (rnd_trunc),
        .flush_zero (flush_zero)
    );

    fp_trap_out u_trap (
        .clk       (clk),
        .rst       (rst),
        .fire      (take_op && hit),
        .trap_req  (trap_req),
        .trap_code (trap_code)
    );

    assign csr_value = word_q;
endmodule

// File: rtl/fp_status_ctl_chk.sv
module fp_status_ctl_chk (
    input logic        clk,
    input logic        rst,
    input logic        ld_en,
    input logic [31:0] ld_data,
    input logic [31:0] csr_value,
    input logic        op_done,
    input logic        op_cmp,
    input logic        op_unordered,
    input logic [4:0]  op_exc,
    input logic        rnd_trunc,
    input logic        flush_zero,
    input logic        trap_req,
    input logic [11:0] trap_code
);
    logic upd;
    assign upd = op_done && !ld_en && !(op_cmp && !op_unordered);

    AST_LOAD_MASK: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> csr_value == ($past(ld_data) & 32'h003F_FFFF)); // R1
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        csr_value[31:22] == 10'd0); // R1
    AST_TRUNC_MAP: assert property (@(posedge clk) disable iff (rst)
        rnd_trunc == (csr_value[1:0] == 2'b01)); // R2
    AST_FLUSH_MAP: assert property (@(posedge clk) disable iff (rst)
        flush_zero == csr_value[18]); // R3
    AST_FLAGS_REWRITE: assert property (@(posedge clk) disable iff (rst)
        upd |=> csr_value[6:2] == $past(op_exc)); // R5
    AST_CAUSE_KEEP: assert property (@(posedge clk) disable iff (rst)
        upd |=> (csr_value[16:12] & $past(csr_value[16:12])) == $past(csr_value[16:12])); // R6
    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        upd |=> csr_value[11:7] == $past(csr_value[11:7])); // R6
    AST_TRAP_CODE: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> trap_code == 12'h120); // R7
    AST_TRAP_AFTER_OP: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> $past(upd)); // R7
    AST_NO_EXC_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
        (op_done && op_exc == 5'd0) |=> !trap_req); // R8
    AST_CMP_ORDERED: assert property (@(posedge clk) disable iff (rst)
        (op_done && op_cmp && !op_unordered && !ld_en) |=> ($stable(csr_value) && !trap_req)); // R9
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (ld_en && op_done) |=> !trap_req); // R10
endmodule

bind fp_status_ctl fp_status_ctl_chk i_chk (.*);

// File: tb/test_fp_status_ctl.sv
module test_fp_status_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [31:0] ld_data = '0;
    logic [31:0] csr_value;
    logic        op_done = 1'b0, op_cmp = 1'b0, op_unordered = 1'b0;
    logic [4:0]  op_exc = '0;
    logic        rnd_trunc, flush_zero, trap_req;
    logic [11:0] trap_code;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_w = '0;
    logic        exp_trap = 1'b0;

    always #2 clk = ~clk;

    fp_status_ctl i_fp_status_ctl (.*);

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
        end
    endtask

    // independent model of one strobe
    task automatic model_op(input logic cmp, input logic unord, input logic [4:0] exc);
        logic [4:0] c;
        exp_trap = 1'b0;
        if (!(cmp && !unord)) begin
            c = exp_w[16:12] | exc;
            exp_w[6:2] = exc;
            exp_w[16:12] = c;
            exp_trap = (exc != 0) && ((c & exp_w[11:7]) != 0);
        end
    endtask

    task automatic do_load(input logic [31:0] d);
        @(negedge clk); ld_en = 1'b1; ld_data = d;
        @(negedge clk); ld_en = 1'b0;
        exp_w = d & 32'h003F_FFFF;
    endtask

    task automatic do_op(input string req, input logic cmp, input logic unord, input logic [4:0] exc);
        @(negedge clk); op_done = 1'b1; op_cmp = cmp; op_unordered = unord; op_exc = exc;
        @(negedge clk); op_done = 1'b0; op_cmp = 1'b0; op_unordered = 1'b0; op_exc = '0;
        model_op(cmp, unord, exc);
        check({req, " word"}, csr_value, exp_w);
        check({req, " trap"}, {31'd0, trap_req}, {31'd0, exp_trap});
        check({req, " code"}, {20'd0, trap_code}, exp_trap ? 32'h120 : 32'h0);
        @(negedge clk);
        check({req, " pulse"}, {31'd0, trap_req}, 32'd0);
    endtask

    task automatic t_reset;
        check("R4 word", csr_value, 32'h0);
        check("R4 outs", {28'd0, rnd_trunc, flush_zero, trap_req, |trap_code}, 32'h0);
    endtask

    task automatic t_load_mask;
        do_load(32'hFFFF_FFFF);
        check("R1 all ones", csr_value, 32'h003F_FFFF);
        do_load(32'hA5A5_A5A5);
        check("R1 pattern", csr_value, 32'h0025_A5A5);
    endtask

    task automatic t_rounding;
        for (int m = 0; m < 4; m++) begin
            do_load(32'(m));
            check("R2 rounding", {31'd0, rnd_trunc}, {31'd0, m == 1});
        end
    endtask

    task automatic t_flush;
        do_load(32'h0004_0000);
        check("R3 flush on", {31'd0, flush_zero}, 32'd1);
        do_load(32'h003B_FFFF);
        check("R3 flush off", {31'd0, flush_zero}, 32'd0);
    endtask

    task automatic t_flags;
        do_load(32'h0000_007C);           // all flags preset, no enables
        do_op("R5 rewrite", 1'b0, 1'b0, 5'b00101);
        do_op("R6 accumulate", 1'b0, 1'b0, 5'b10010);
        check("R6 cause", {27'd0, csr_value[16:12]}, 32'h17);
    endtask

    task automatic t_trap;
        do_load(32'h0000_0800 | 32'h0008_0003);  // invalid enabled, spare/rounding set
        do_op("R7 enabled miss", 1'b0, 1'b0, 5'b00001);
        do_op("R7 invalid trap", 1'b0, 1'b0, 5'b10000);
        do_op("R8 zero exc", 1'b0, 1'b0, 5'b00000);
        do_op("R7 retrap", 1'b0, 1'b0, 5'b00010);
    endtask

    task automatic t_compare;
        do_load(32'h0000_0F80);           // all enables
        do_op("R9 ordered", 1'b1, 1'b0, 5'b10000);
        check("R9 ordered flags", {27'd0, csr_value[6:2]}, 32'd0);
        do_op("R9 unordered", 1'b1, 1'b1, 5'b10000);
    endtask

    task automatic t_collision;
        @(negedge clk);
        ld_en = 1'b1; ld_data = 32'h0000_0F80;
        op_done = 1'b1; op_exc = 5'b11111;
        @(negedge clk);
        ld_en = 1'b0; op_done = 1'b0; op_exc = '0;
        check("R10 word", csr_value, 32'h0000_0F80);
        check("R10 trap", {31'd0, trap_req}, 32'd0);
        exp_w = 32'h0000_0F80;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load_mask();
        t_rounding();
        t_flush();
        t_flags();
        t_trap();
        t_compare();
        t_collision();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #40000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired got=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule